// File: doc/BRIEF.md
# Two-level group carry-lookahead adder

This block is a purely combinational adder of K = N x M bits. The operands are cut into M slices of N bits each. Slice 0 takes the lowest N bits, and each later slice takes the next N bits above it. Every slice adds its own bits and reports two single-bit summaries: a group generate and a group propagate. A shared second-level network takes those summaries and the incoming carry. It forms the carry into every slice directly with expanded lookahead equations, so no carry ripples from one slice to the next.

A build-time parameter picks how the inside of each slice works:

- **Lookahead slice.** Every bit carry comes from flattened lookahead terms.
- **Ripple slice.** The bit carries ripple through full adders, and the group generate and propagate are built up towards the slice's top bit.

The carries between slices are lookahead carries in both variants.

A subtract control turns the block into an A minus B unit. It inverts B and forces the carry-in, in two's complement. The outputs are the sum, the unsigned carry-out and a signed overflow flag. The block is meant to sit inside a registered datapath stage, where the surrounding logic supplies the clocking.

Top module: `gcla_adder`

## Requirements
- R1: With sub = 0, sum equals (a + b + cin) modulo 2^K, for every operand pattern.
- R2: With sub = 0, cout equals bit K of the (K+1)-bit value a + b + cin. Adding 1 to all ones gives sum 0 and cout 1.
- R3: With sub = 1, sum equals (a - b) modulo 2^K and cout equals 1 exactly when a >= b as unsigned numbers. The cin input is ignored while sub = 1.
- R4: ovf is 1 exactly when the two's-complement result leaves the signed range. For addition, this means a and b have the same sign bit and the sign bit of sum differs from it. For subtraction, it means a and b have different sign bits and the sign bit of sum differs from that of a.
- R5: The ripple slice variant (KIND = SLICE_RIPPLE) produces the same sum, cout and ovf as the lookahead variant for every input.
- R6: The carry into slice i+1 equals G_i OR (P_i AND carry into slice i), starting from the effective carry-in. When every bit propagates and cin = 1 (a = 0xAAAA, b = 0x5555 at K = 16), the result is sum 0 and cout 1.
- R7: A slice's group generate is 1 when the slice produces a carry out by itself. Its group propagate is 1 when every bit of the slice propagates. So a carry generated inside one slice reaches the slice above it: 0x0080 + 0x0080 gives 0x0100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | K | First operand |
| b | input | K | Second operand (subtrahend when sub = 1) |
| cin | input | 1 | Carry-in for addition; ignored when sub = 1 |
| sub | input | 1 | 1 selects a - b, 0 selects a + b + cin |
| sum | output | K | Result modulo 2^K |
| cout | output | 1 | Carry out of the top slice |
| ovf | output | 1 | Signed overflow of the result |

## Verification
Zero operands confirm that no carry appears from nothing. All ones plus one and the all-propagate pattern with cin = 1 push a single carry across every slice boundary, which tells a working lookahead network from one that drops a term. A generate confined to one slice separates a correct group generate from a bad one. Signed-range edge cases and subtraction pairs around equality tell overflow and borrow apart. Long random runs compare both slice variants against a plain arithmetic model.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
  typedef enum logic {
    SLICE_LOOKAHEAD = 1'b0,
    SLICE_RIPPLE    = 1'b1
  } slice_kind_e;
endpackage

// File: rtl/gcla_slice_lookahead.sv
module gcla_slice_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         grp_g,
  output logic         grp_p
);
  logic [N-1:0] gen, prp, cbit;
  logic         run, gacc;

  assign gen = a & b;
  assign prp = a ^ b;

  // flattened lookahead carries into each bit of the slice
  always_comb begin
    cbit    = '0;
    cbit[0] = cin;
    run     = 1'b0;
    for (int j = 1; j < N; j++) begin
      for (int i = 0; i < j; i++) begin
        run = gen[i];
        for (int t = i + 1; t < j; t++) run = run & prp[t];
        cbit[j] = cbit[j] | run;
      end
      run = cin;
      for (int t = 0; t < j; t++) run = run & prp[t];
      cbit[j] = cbit[j] | run;
    end
  end

  // group generate as the same flattened form, without carry-in
  always_comb begin
    gacc = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic term;
      term = gen[i];
      for (int t = i + 1; t < N; t++) term = term & prp[t];
      gacc = gacc | term;
    end
  end

  assign grp_g = gacc;
  assign grp_p = &prp;
  assign sum   = prp ^ cbit;

  always_comb begin
    // R7
    slice_group_chk: assert ({grp_g | (grp_p & cin), sum} ==
                             ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}));
    // R7
    slice_excl_chk: assert (!(grp_p && grp_g));
  end
endmodule

// File: rtl/gcla_slice_ripple.sv
module gcla_slice_ripple #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         grp_g,
  output logic         grp_p
);
  logic [N-1:0] gen, prp, cbit;
  logic         gacc;

  assign gen     = a & b;
  assign prp     = a ^ b;
  assign cbit[0] = cin;

  for (genvar j = 0; j < N; j++) begin : g_fa
    assign sum[j] = prp[j] ^ cbit[j];
    if (j < N - 1) begin : g_chain
      assign cbit[j+1] = gen[j] | (prp[j] & cbit[j]);
    end
  end

  // group terms accumulated up to the top bit of the slice
  always_comb begin
    gacc = 1'b0;
    for (int j = 0; j < N; j++) gacc = gen[j] | (prp[j] & gacc);
  end

  assign grp_g = gacc;
  assign grp_p = &prp;

  always_comb begin
    // R7
    ripple_group_chk: assert ({grp_g | (grp_p & cin), sum} ==
                              ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}));
  end
endmodule

// File: rtl/gcla_carry_net.sv
module gcla_carry_net #(
  parameter int M = 4
) (
  input  logic [M-1:0] gg,
  input  logic [M-1:0] gp,
  input  logic         c0,
  output logic [M:0]   cm
);
  logic run;

  always_comb begin
    cm    = '0;
    cm[0] = c0;
    run   = 1'b0;
    for (int j = 1; j <= M; j++) begin
      for (int i = 0; i < j; i++) begin
        run = gg[i];
        for (int t = i + 1; t < j; t++) run = run & gp[t];
        cm[j] = cm[j] | run;
      end
      run = c0;
      for (int t = 0; t < j; t++) run = run & gp[t];
      cm[j] = cm[j] | run;
    end
  end

  always_comb begin
    for (int i = 0; i < M; i++) begin
      // R6
      net_link_chk: assert (cm[i+1] == (gg[i] | (gp[i] & cm[i])));
    end
  end
endmodule

// File: rtl/gcla_adder.sv
module gcla_adder #(
  parameter int                    N    = 4,
  parameter int                    M    = 4,
  parameter gcla_pkg::slice_kind_e KIND = gcla_pkg::SLICE_LOOKAHEAD,
  localparam int                   K    = N * M
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [K-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [K-1:0] b_eff;
  logic         c_eff;
  logic [M-1:0] gg, gp;
  logic [M:0]   cm;
  logic         c_into_msb;

  assign b_eff = sub ? ~b : b;
  assign c_eff = sub | cin;

  for (genvar i = 0; i < M; i++) begin : g_slice
    if (KIND == gcla_pkg::SLICE_LOOKAHEAD) begin : g_la
      gcla_slice_lookahead #(.N(N)) u_slice (
        .a    (a[i*N +: N]),
        .b    (b_eff[i*N +: N]),
        .cin  (cm[i]),
        .sum  (sum[i*N +: N]),
        .grp_g(gg[i]),
        .grp_p(gp[i])
      );
    end else begin : g_rc
      gcla_slice_ripple #(.N(N)) u_slice (
        .a    (a[i*N +: N]),
        .b    (b_eff[i*N +: N]),
        .cin  (cm[i]),
        .sum  (sum[i*N +: N]),
        .grp_g(gg[i]),
        .grp_p(gp[i])
      );
    end
  end

  gcla_carry_net #(.M(M)) u_net (
    .gg(gg),
    .gp(gp),
    .c0(c_eff),
    .cm(cm)
  );

  assign cout       = cm[M];
  assign c_into_msb = sum[K-1] ^ a[K-1] ^ b_eff[K-1];
  assign ovf        = cout ^ c_into_msb;

  always_comb begin
    // R1
    add_result_chk: assert ({cout, sum} ==
                            ({1'b0, a} + {1'b0, b_eff} + {{K{1'b0}}, c_eff}));
    // R4
    no_overflow_chk: assert (ovf == ((a[K-1] == b_eff[K-1]) && (sum[K-1] != a[K-1])));
  end
endmodule

// File: tb/gcla_adder_test.sv
module gcla_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int M = 4;
  localparam int K = N * M;

  logic clk = 1'b0;
  logic [K-1:0] a = '0, b = '0;
  logic cin = 1'b0, sub = 1'b0;
  logic [K-1:0] sum_la, sum_rc;
  logic cout_la, cout_rc, ovf_la, ovf_rc;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcla_adder #(.N(N), .M(M), .KIND(gcla_pkg::SLICE_LOOKAHEAD)) uut (
    .a(a), .b(b), .cin(cin), .sub(sub), .sum(sum_la), .cout(cout_la), .ovf(ovf_la));
  gcla_adder #(.N(N), .M(M), .KIND(gcla_pkg::SLICE_RIPPLE)) uut_rpl (
    .a(a), .b(b), .cin(cin), .sub(sub), .sum(sum_rc), .cout(cout_rc), .ovf(ovf_rc));

  task automatic chk(input string req, input logic [K:0] act, input logic [K:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [K-1:0] xa, input logic [K-1:0] xb,
                          input logic xcin, input logic xsub);
    logic [K:0] full;
    logic       eovf;
    @(negedge clk);
    a = xa; b = xb; cin = xcin; sub = xsub;
    #1;
    if (xsub) begin
      full = {1'b0, xa} + {1'b0, ~xb} + {{K{1'b0}}, 1'b1};
      eovf = (xa[K-1] != xb[K-1]) && (full[K-1] != xa[K-1]);
    end else begin
      full = {1'b0, xa} + {1'b0, xb} + {{K{1'b0}}, xcin};
      eovf = (xa[K-1] == xb[K-1]) && (full[K-1] != xa[K-1]);
    end
    chk({tag, " sum"},  {1'b0, sum_la}, {1'b0, full[K-1:0]});
    chk({tag, " cout"}, {{K{1'b0}}, cout_la}, {{K{1'b0}}, full[K]});
    chk({"R4 ovf ", tag}, {{K{1'b0}}, ovf_la}, {{K{1'b0}}, eovf});
    chk({"R5 ripple sum ", tag},  {1'b0, sum_rc}, {1'b0, full[K-1:0]});
    chk({"R5 ripple cout ", tag}, {{K{1'b0}}, cout_rc}, {{K{1'b0}}, full[K]});
    chk({"R5 ripple ovf ", tag},  {{K{1'b0}}, ovf_rc}, {{K{1'b0}}, eovf});
  endtask

  task automatic t_zero;
    run_case("R1 zero", '0, '0, 1'b0, 1'b0);
    run_case("R2 zero cin", '0, '0, 1'b1, 1'b0);
  endtask

  task automatic t_ones_plus_one;
    run_case("R2 ones+1", '1, 16'h0001, 1'b0, 1'b0);
    run_case("R2 ones+cin", '1, '0, 1'b1, 1'b0);
    @(negedge clk); #1;
    chk("R2 ones+cin cout direct", {{K{1'b0}}, cout_la}, {{K{1'b0}}, 1'b1});
  endtask

  task automatic t_all_propagate;
    run_case("R6 allprop cin1", 16'hAAAA, 16'h5555, 1'b1, 1'b0);
    chk("R6 allprop sum zero", {1'b0, sum_la}, '0);
    run_case("R6 allprop cin0", 16'hAAAA, 16'h5555, 1'b0, 1'b0);
    run_case("R6 slice2 prop", 16'h0F0F, 16'h00F1, 1'b0, 1'b0);
  endtask

  task automatic t_group_gen;
    run_case("R7 gen slice1", 16'h0080, 16'h0080, 1'b0, 1'b0);
    chk("R7 gen slice1 value", {1'b0, sum_la}, {1'b0, 16'h0100});
    run_case("R7 gen top", 16'hF000, 16'h1000, 1'b0, 1'b0);
    run_case("R7 gen chain", 16'h08F0, 16'h0810, 1'b1, 1'b0);
  endtask

  task automatic t_subtract;
    run_case("R3 5-3", 16'd5, 16'd3, 1'b0, 1'b1);
    run_case("R3 3-5", 16'd3, 16'd5, 1'b0, 1'b1);
    run_case("R3 eq", 16'h1234, 16'h1234, 1'b0, 1'b1);
    run_case("R3 min-1", 16'h8000, 16'h0001, 1'b0, 1'b1);
    run_case("R3 0-max", 16'h0000, 16'h7FFF, 1'b0, 1'b1);
    // cin must have no effect while subtracting
    run_case("R3 cin ignored", 16'd5, 16'd3, 1'b1, 1'b1);
    chk("R3 cin ignored value", {1'b0, sum_la}, {1'b0, 16'd2});
  endtask

  task automatic t_overflow;
    run_case("R4 max+1", 16'h7FFF, 16'h0001, 1'b0, 1'b0);
    run_case("R4 min+min", 16'h8000, 16'h8000, 1'b0, 1'b0);
    run_case("R4 mixed", 16'h7FFF, 16'h8000, 1'b1, 1'b0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 2000; n++) begin
      logic [K-1:0] ra, rb;
      logic rc, rs;
      ra = K'($urandom);
      rb = K'($urandom);
      rc = 1'($urandom);
      rs = 1'($urandom);
      if (rs) run_case("R3 random", ra, rb, rc, rs);
      else    run_case("R1 random", ra, rb, rc, rs);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_zero();
    t_ones_plus_one();
    t_all_propagate();
    t_group_gen();
    t_subtract();
    t_overflow();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule